// File: doc/BRIEF.md
# Binary Difference-of-Gaussian Engine

This block takes a raster stream of one-bit pixels and returns, for every pixel, a signed Difference-of-Gaussian response. It runs two smoothing filters side by side on the same stream. The narrow filter uses a 5x5 kernel for the base scale, with a standard deviation of about 1.4. The wide filter uses a 9x9 kernel at twice that scale. Each output is the wide-blur value minus the narrow-blur value. The sign is kept so that a later stage can search for extrema.

Neither filter has a multiply-accumulate datapath. For each kernel column, the vertical group of binary pixels forms a table address. The table returns the column's weighted contribution, with the horizontal weight for that column already folded in. One adder tree per path then adds the column contributions. Both paths read their pixels from one shared 9x9 window, and the 5x5 window sits at its centre. The two results therefore refer to the same pixel without a separate delay line.

A small control FSM tracks the frame. A start-of-frame pixel clears all history. After the last line of a frame, the FSM produces its own zero-pixel steps to drain the bottom rows.

The FSM has four states:
- IDLE: waiting; pixels without a frame start are ignored.
- PRIME: the window is filling and no output is produced.
- STREAM: one output per accepted pixel.
- DRAIN: one internal zero step per cycle; input is ignored.

Its transitions:
- A frame-start pixel moves the FSM from any state to PRIME.
- PRIME goes to STREAM once the fill count reaches the lag.
- STREAM goes to DRAIN on the line-end marker of the last row.
- DRAIN goes to IDLE on the final output of the frame.

Top module: `dog_engine`

## Requirements
- R1: For an image of width IMG_W and height IMG_H, the output for pixel (r,c) is the sum of the wide weights over its 9x9 neighbourhood minus the sum of the narrow weights over its 5x5 neighbourhood. Each sum counts only pixels equal to 1. The result is a 10-bit two's-complement value.
- R2: The one-dimensional narrow taps are 2,4,4,4,2 and the wide taps are 1,2,2,2,2,2,2,2,1. A 2-D weight is the product of a row tap and a column tap. Each 2-D kernel therefore sums to 256, which is 8 fractional bits. An all-white neighbourhood gives a response of 0.
- R3: Neighbours outside the image, in any direction, count as 0 pixels.
- R4: Each frame produces exactly IMG_W*IMG_H outputs, in raster order.
- R5: dog_valid is low after reset. It first goes high exactly 3 cycles after the clock edge that accepts pixel number LAG of the frame, where LAG = 4*IMG_W+4 and pixels are counted from 0.
- R6: The last-row line end moves the block into DRAIN. The last output of the frame then appears exactly LAG+3 cycles after that line end is accepted, with no further input.
- R7: A start-of-frame pixel (pix_valid and pix_sof both high) clears the pixel history and any results still in flight. Content from an earlier or aborted frame never reaches the new frame's outputs.
- R8: Pixels without a start-of-frame marker are ignored in IDLE and in DRAIN.
- R9: A cycle with pix_valid low changes nothing, so gaps in the stream leave the results unchanged.
- R10: Every output lies in the range -256 to +256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | The pixel on pix_bit is presented this cycle |
| pix_bit | input | 1 | Binary pixel, 1 = white |
| pix_sof | input | 1 | Marks the first pixel of a frame |
| pix_eol | input | 1 | Marks the last pixel of a line |
| dog_valid | output | 1 | dog_value holds a result |
| dog_value | output | 10 | Signed wide-minus-narrow response |

## Verification
The bench aims at the places where pixel geometry goes wrong. Isolated dots and rings on the frame edge are used because a design that forgets column masking would pull pixels from the wrapped neighbouring line into edge outputs. An all-white frame exposes any kernel that does not sum to 256, since interior responses would then be nonzero. A frame aborted during fill and followed by a black frame shows leakage from stale line history, and a wrong drain length or a wrong pipeline depth moves the first or last output away from the exact expected cycle. Noise pixels sent during drain and idle would appear as extra or corrupted outputs if they were not ignored.

// File: rtl/dog_pkg.sv
`timescale 1ns/1ps
package dog_pkg;
    localparam int SM_TAPS = 5;
    localparam int LG_TAPS = 9;
    localparam int SM_RAD  = (SM_TAPS - 1) / 2;
    localparam int LG_RAD  = (LG_TAPS - 1) / 2;
    localparam int KSUM    = 256;
    localparam int MAX_TAP = 4;
    localparam int COL_W   = $clog2(MAX_TAP * 16 + 1);
    localparam int BLUR_W  = $clog2(KSUM + 1);
    localparam int DOG_W   = BLUR_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIME  = 2'd1,
        ST_STREAM = 2'd2,
        ST_DRAIN  = 2'd3
    } dog_state_e;

    // one-dimensional tap weights; the 2-D weight is a row tap times a column tap
    function automatic int tap_w(bit wide, int idx);
        if (wide)
            return (idx == 0 || idx == LG_TAPS - 1) ? 1 : 2;
        else
            return (idx == 0 || idx == SM_TAPS - 1) ? 2 : 4;
    endfunction
endpackage

// File: rtl/dog_ctrl.sv
`timescale 1ns/1ps
module dog_ctrl
    import dog_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_bit,
    input  logic                      in_sof,
    input  logic                      in_eol,
    output logic                      step,
    output logic                      shift_bit,
    output logic                      clr,
    output logic                      win_live,
    output logic [$clog2(IMG_W)-1:0]  win_col
);
    localparam int LAG    = LG_RAD * IMG_W + LG_RAD;
    localparam int TOTAL  = IMG_W * IMG_H;
    localparam int FILL_W = $clog2(LAG + 1);
    localparam int CNT_W  = $clog2(TOTAL + 1);
    localparam int XW     = $clog2(IMG_W);
    localparam int ROW_W  = $clog2(IMG_H);

    dog_state_e        state_q, state_d;
    logic [FILL_W-1:0] fill_cnt;
    logic [CNT_W-1:0]  out_cnt;
    logic [ROW_W-1:0]  in_row;
    logic [XW-1:0]     out_col;
    logic              emit;
    logic              win_live_q;
    logic [XW-1:0]     win_col_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and step outputs
    always_comb begin
        state_d   = state_q;
        step      = 1'b0;
        shift_bit = 1'b0;
        clr       = 1'b0;
        if (in_valid && in_sof) begin
            step      = 1'b1;
            clr       = 1'b1;
            shift_bit = in_bit;
            state_d   = ST_PRIME;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_PRIME: begin
                    if (in_valid) begin
                        step      = 1'b1;
                        shift_bit = in_bit;
                        if (fill_cnt == FILL_W'(LAG - 1)) state_d = ST_STREAM;
                    end
                end
                ST_STREAM: begin
                    if (in_valid) begin
                        step      = 1'b1;
                        shift_bit = in_bit;
                        if (in_eol && in_row == ROW_W'(IMG_H - 1)) state_d = ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    step = 1'b1;
                    if (out_cnt == CNT_W'(TOTAL - 1)) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
        emit = step && !clr && (fill_cnt == FILL_W'(LAG));
    end

    // position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_cnt   <= '0;
            out_cnt    <= '0;
            in_row     <= '0;
            out_col    <= '0;
            win_live_q <= 1'b0;
            win_col_q  <= '0;
        end else begin
            win_live_q <= emit;
            win_col_q  <= out_col;
            if (clr) begin
                fill_cnt <= FILL_W'(1);
                out_cnt  <= '0;
                in_row   <= '0;
                out_col  <= '0;
            end else if (step) begin
                if (fill_cnt != FILL_W'(LAG)) fill_cnt <= fill_cnt + 1'b1;
                if (state_q != ST_DRAIN && in_eol) in_row <= in_row + 1'b1;
                if (emit) begin
                    out_cnt <= out_cnt + 1'b1;
                    out_col <= (out_col == XW'(IMG_W - 1)) ? '0 : out_col + 1'b1;
                end
            end
        end
    end

    assign win_live = win_live_q;
    assign win_col  = win_col_q;

    a_r5_prime_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME) |-> !emit);
    a_r6_drain_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> (fill_cnt == FILL_W'(LAG)));
    a_r4_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt <= CNT_W'(TOTAL));
    a_r9_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && state_q != ST_DRAIN) |=> ($stable(fill_cnt) && $stable(out_cnt)));
    a_r8_idle_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !(in_valid && in_sof)) |=> (state_q == ST_IDLE && $stable(out_cnt)));
endmodule

// File: rtl/dog_window.sv
`timescale 1ns/1ps
module dog_window
    import dog_pkg::*;
#(
    parameter int IMG_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         step,
    input  logic                         clr,
    input  logic                         bit_in,
    output logic [LG_TAPS*LG_TAPS-1:0]   win
);
    localparam int CH = (LG_TAPS - 1) * IMG_W + LG_TAPS;

    logic [CH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain <= '0;
        else if (step) begin
            if (clr) chain <= {{(CH-1){1'b0}}, bit_in};
            else     chain <= {chain[CH-2:0], bit_in};
        end
    end

    // window row r / column c sits (8-r) lines and (8-c) pixels behind the newest pixel
    for (genvar r = 0; r < LG_TAPS; r++) begin : g_row
        for (genvar c = 0; c < LG_TAPS; c++) begin : g_col
            assign win[r*LG_TAPS + c] = chain[(LG_TAPS-1-r)*IMG_W + (LG_TAPS-1-c)];
        end
    end

    a_r7_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        (step && clr) |=> (chain[CH-1:1] == '0));
endmodule

// File: rtl/dog_col_lut.sv
`timescale 1ns/1ps
module dog_col_lut
    import dog_pkg::*;
#(
    parameter int TAPS = 5,
    parameter bit WIDE = 1'b0,
    parameter int COL  = 0
) (
    input  logic [TAPS-1:0]  col_bits,
    input  logic             col_en,
    output logic [COL_W-1:0] col_val
);
    // table addressed by the column's bit group; entries hold the weighted
    // column sum with this column's horizontal tap already applied
    always_comb begin
        logic [COL_W-1:0] acc;
        acc = '0;
        for (int r = 0; r < TAPS; r++) begin
            if (col_bits[r]) acc = acc + COL_W'(tap_w(WIDE, r) * tap_w(WIDE, COL));
        end
        col_val = col_en ? acc : '0;
    end
endmodule

// File: rtl/dog_blur_path.sv
`timescale 1ns/1ps
module dog_blur_path
    import dog_pkg::*;
#(
    parameter int TAPS = 5,
    parameter bit WIDE = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    win_live,
    input  logic [TAPS*TAPS-1:0]    win,
    input  logic [TAPS-1:0]         col_ok,
    output logic                    blur_vld,
    output logic [BLUR_W-1:0]       blur_val
);
    logic [COL_W-1:0]  col_v [TAPS];
    logic [COL_W-1:0]  col_q [TAPS];
    logic              vld1;
    logic [BLUR_W-1:0] tot;

    for (genvar c = 0; c < TAPS; c++) begin : g_col
        logic [TAPS-1:0] bits;
        for (genvar r = 0; r < TAPS; r++) begin : g_bit
            assign bits[r] = win[r*TAPS + c];
        end
        dog_col_lut #(.TAPS(TAPS), .WIDE(WIDE), .COL(c)) u_lut (
            .col_bits (bits),
            .col_en   (col_ok[c]),
            .col_val  (col_v[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld1 <= 1'b0;
            for (int c = 0; c < TAPS; c++) col_q[c] <= '0;
        end else begin
            vld1 <= win_live && !clr;
            for (int c = 0; c < TAPS; c++) col_q[c] <= col_v[c];
        end
    end

    always_comb begin
        tot = '0;
        for (int c = 0; c < TAPS; c++) tot = tot + BLUR_W'(col_q[c]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blur_vld <= 1'b0;
            blur_val <= '0;
        end else begin
            blur_vld <= vld1 && !clr;
            blur_val <= tot;
        end
    end

    a_r2_sum_cap: assert property (@(posedge clk) disable iff (!rst_n)
        blur_vld |-> (blur_val <= BLUR_W'(KSUM)));
endmodule

// File: rtl/dog_engine.sv
`timescale 1ns/1ps
module dog_engine
    import dog_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pix_valid,
    input  logic                    pix_bit,
    input  logic                    pix_sof,
    input  logic                    pix_eol,
    output logic                    dog_valid,
    output logic signed [DOG_W-1:0] dog_value
);
    localparam int XW  = $clog2(IMG_W);
    localparam int OFF = LG_RAD - SM_RAD;

    logic                         step, shift_bit, clr, win_live;
    logic [XW-1:0]                win_col;
    logic [LG_TAPS*LG_TAPS-1:0]   win;
    logic [SM_TAPS*SM_TAPS-1:0]   sm_win;
    logic [LG_TAPS-1:0]           col_ok;
    logic                         sm_vld, lg_vld;
    logic [BLUR_W-1:0]            sm_val, lg_val;

    dog_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pix_valid),
        .in_bit    (pix_bit),
        .in_sof    (pix_sof),
        .in_eol    (pix_eol),
        .step      (step),
        .shift_bit (shift_bit),
        .clr       (clr),
        .win_live  (win_live),
        .win_col   (win_col)
    );

    dog_window #(.IMG_W(IMG_W)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .clr    (clr),
        .bit_in (shift_bit),
        .win    (win)
    );

    // horizontal border mask, per window column
    always_comb begin
        for (int c = 0; c < LG_TAPS; c++) begin
            int pos;
            pos = int'(win_col) + c - LG_RAD;
            col_ok[c] = (pos >= 0) && (pos < IMG_W);
        end
    end

    // the narrow kernel reads the centre of the shared wide window
    for (genvar r = 0; r < SM_TAPS; r++) begin : g_sm_row
        for (genvar c = 0; c < SM_TAPS; c++) begin : g_sm_col
            assign sm_win[r*SM_TAPS + c] = win[(r+OFF)*LG_TAPS + c + OFF];
        end
    end

    dog_blur_path #(.TAPS(SM_TAPS), .WIDE(1'b0)) u_narrow (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .win_live (win_live),
        .win      (sm_win),
        .col_ok   (col_ok[OFF +: SM_TAPS]),
        .blur_vld (sm_vld),
        .blur_val (sm_val)
    );

    dog_blur_path #(.TAPS(LG_TAPS), .WIDE(1'b1)) u_wide (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .win_live (win_live),
        .win      (win),
        .col_ok   (col_ok),
        .blur_vld (lg_vld),
        .blur_val (lg_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dog_valid <= 1'b0;
            dog_value <= '0;
        end else begin
            dog_valid <= sm_vld && lg_vld && !clr;
            dog_value <= $signed({1'b0, lg_val}) - $signed({1'b0, sm_val});
        end
    end

    a_r1_paths_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        sm_vld == lg_vld);
    a_r10_dog_range: assert property (@(posedge clk) disable iff (!rst_n)
        dog_valid |-> (dog_value >= -DOG_W'(KSUM) && dog_value <= DOG_W'(KSUM)));
endmodule

// File: tb/dog_engine_tb_top.sv
`timescale 1ns/1ps
module dog_engine_tb_top;
    localparam int W   = 16;
    localparam int H   = 12;
    localparam int LAG = 4 * W + 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pix_valid = 1'b0, pix_bit = 1'b0, pix_sof = 1'b0, pix_eol = 1'b0;
    logic              dog_valid;
    logic signed [9:0] dog_value;

    int    total = 0, bad = 0, cyc = 0;
    int    got = 0, first_cyc = -1, last_cyc = -1;
    int    exp_q[$];
    string cur_tag = "R4";
    bit    img [H][W];

    always #2.5 clk = ~clk;

    dog_engine #(.IMG_W(W), .IMG_H(H)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .pix_bit   (pix_bit),
        .pix_sof   (pix_sof),
        .pix_eol   (pix_eol),
        .dog_valid (dog_valid),
        .dog_value (dog_value)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string tag, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int wl(int i);
        return (i == 0 || i == 8) ? 1 : 2;
    endfunction
    function automatic int ws(int i);
        return (i == 0 || i == 4) ? 2 : 4;
    endfunction
    function automatic int px(int r, int c);
        if (r < 0 || r >= H || c < 0 || c >= W) return 0;
        return int'(img[r][c]);
    endfunction
    function automatic int model(int r, int c);
        int lg = 0, sm = 0;
        for (int dr = -4; dr <= 4; dr++)
            for (int dc = -4; dc <= 4; dc++)
                lg += wl(dr + 4) * wl(dc + 4) * px(r + dr, c + dc);
        for (int dr = -2; dr <= 2; dr++)
            for (int dc = -2; dc <= 2; dc++)
                sm += ws(dr + 2) * ws(dc + 2) * px(r + dr, c + dc);
        return lg - sm;
    endfunction

    // compare every output against the queued expectation, in order
    always @(negedge clk) begin
        if (rst_n && dog_valid) begin
            got++;
            if (first_cyc < 0) first_cyc = cyc;
            last_cyc = cyc;
            if (exp_q.size() == 0) begin
                chk(1'b0, {cur_tag, " R4 unexpected output"}, int'(dog_value), 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(dog_value) == e, {cur_tag, " R1 value"}, int'(dog_value), e);
            end
        end
    end

    task automatic idle(int n, bit noise);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_valid = noise ? 1'($urandom) : 1'b0;
            pix_bit   = 1'($urandom);
            pix_sof   = 1'b0;
            pix_eol   = noise ? 1'($urandom) : 1'b0;
        end
    endtask

    task automatic drive_px(bit b, bit sof, bit eol, output int acc);
        @(negedge clk);
        pix_valid = 1'b1;
        pix_bit   = b;
        pix_sof   = sof;
        pix_eol   = eol;
        acc       = cyc + 1;
    endtask

    task automatic run_frame(int pat, bit gaps, string tag, bit noise_after);
        int acc, acc_lag, acc_last;
        acc_lag = 0;
        acc_last = 0;
        cur_tag = tag;
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                case (pat)
                    0: img[r][c] = 1'($urandom);
                    1: img[r][c] = 1'b1;
                    2: img[r][c] = (r == 5 && c == 7);
                    3: img[r][c] = 1'b0;
                    default: img[r][c] = (r == 0 || r == H-1 || c == 0 || c == W-1);
                endcase
            end
        exp_q.delete();
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) exp_q.push_back(model(r, c));
        got = 0;
        first_cyc = -1;
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                if (gaps && ($urandom % 3 == 0)) idle(1 + $urandom % 2, 1'b0);
                drive_px(img[r][c], (r == 0 && c == 0), (c == W - 1), acc);
                if (r * W + c == LAG) acc_lag = acc;
                if (r == H - 1 && c == W - 1) acc_last = acc;
            end
        idle(LAG + 8, noise_after);
        idle(2, 1'b0);
        chk(got == W * H, {tag, " R4 output count"}, got, W * H);
        chk(exp_q.size() == 0, {tag, " R4 missing outputs"}, exp_q.size(), 0);
        chk(first_cyc == acc_lag + 3, {tag, " R5 first output cycle"}, first_cyc, acc_lag + 3);
        chk(last_cyc == acc_last + LAG + 3, {tag, " R6 drain end cycle"}, last_cyc, acc_last + LAG + 3);
    endtask

    initial begin
        int acc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dog_valid == 1'b0, "R5 reset valid low", int'(dog_valid), 0);

        // R8: stray pixels in IDLE produce nothing
        cur_tag = "R8 idle";
        got = 0;
        idle(40, 1'b1);
        idle(6, 1'b0);
        chk(got == 0, "R8 idle pixels ignored", got, 0);

        run_frame(0, 1'b0, "R1 random", 1'b0);
        run_frame(1, 1'b0, "R2 all white", 1'b0);
        run_frame(2, 1'b0, "R2 impulse", 1'b0);
        run_frame(4, 1'b0, "R3 border ring", 1'b0);
        run_frame(0, 1'b1, "R9 gapped stream", 1'b0);
        run_frame(0, 1'b0, "R8 drain noise", 1'b1);

        // R7: abort a white frame during fill, then a black frame must be all zero
        cur_tag = "R7 abort";
        got = 0;
        for (int i = 0; i < 30; i++) drive_px(1'b1, (i == 0), ((i % W) == W - 1), acc);
        idle(6, 1'b0);
        chk(got == 0, "R7 aborted frame silent", got, 0);
        run_frame(3, 1'b0, "R7 restart black", 1'b0);
        run_frame(0, 1'b0, "R7 back to back", 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R4 actual=timeout expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule